// File: doc/BRIEF.md
# Paged Vertical Microsequencer with Coroutine Pointer Table

This block is the sequencing core of a vertically encoded control processor. It fetches 8-bit microinstructions from a 4096-word synchronous control store. The fetch address is a 12-bit value: a 4-bit page number sits above an 8-bit in-page counter. Each ordinary microinstruction is turned into a single strobe, one wire per opcode, and the functional units use these strobes to move data. A small set of reserved opcodes changes the flow instead. These are a two-word in-page jump, a jump to word zero of the current page, and a bus-steered dispatch. In the dispatch, whichever functional unit wins priority places a 12-bit microroutine address on the bus, and that address is loaded as the next fetch address.

The block also keeps a 16-slot table of 12-bit resume pointers. A swap microinstruction exchanges the fetch address with one table slot. A device routine that is split into segments can therefore hand control back and later resume at its next segment, with no test-and-branch sequence. A second opcode fills a slot from the bus, to start a routine or to set up a subroutine link. A hold input freezes the whole sequencer, for instance while a memory access has not yet completed. A write port on the control store lets pages be reloaded.

Top module: `microseq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `uaddr` is 0 and no strobe and no `decode_req` is active. The word at address 0 is executed in the cycle after that.
- R2: An opcode from 0x00 to 0xBF executes in one cycle and raises only `strobe[opcode]`. The in-page counter then advances by one and wraps from 0xFF to 0x00 without changing the page.
- R3: Opcode 0xC0 is a jump that uses two words and two cycles. The following word is an in-page target, and execution continues at {page, target}. No strobe is raised in either cycle.
- R4: Opcode 0xC1 executes in one cycle and continues at word 0 of the current page.
- R5: Opcode 0xC2 executes in one cycle and raises `decode_req`. The next address is taken from `bus_in`.
- R6: Opcode 0xE0 plus slot s (s from 0 to 15) writes `bus_in` into pointer slot s in one cycle, raises no strobe, and advances the counter.
- R7: Opcode 0xF0 plus slot s takes two cycles with no strobe. Execution then continues at the old contents of slot s, and slot s now holds the address of the word after the swap opcode.
- R8: While `hold` is high, no strobe and no `decode_req` is active. No register, slot or fetch address changes.
- R9: Opcodes 0xC3 to 0xDF do nothing for one cycle and raise no strobe.
- R10: At most one strobe is active in any cycle.
- R11: A word written through the control store write port is the word fetched from that address afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Freeze request from an interlock |
| bus_in | input | 12 | Address field of the shared bus, used by dispatch and slot load |
| cs_we | input | 1 | Control store write enable |
| cs_waddr | input | 12 | Control store write address |
| cs_wdata | input | 8 | Control store write data |
| uaddr | output | 12 | Address of the microinstruction now in execution |
| strobe | output | 192 | One-hot strobes, one per ordinary opcode |
| decode_req | output | 1 | Dispatch in progress; bus_in is sampled |

## Verification
A hold request can arrive in the same cycle as any flow change. This includes the second cycle of a swap and the cycle of a bus dispatch. If it does, the swap or dispatch must wait and then take effect exactly once. The bench randomises `hold` on about one cycle in five over a program full of swaps, slot loads, dispatches and jumps. A cycle-by-cycle model of the sequencer predicts the address, the strobe and the dispatch flag. A slot written twice, or a dispatch taken while frozen, would show up as a wrong address later in the run.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int PAGE_W   = 4;
    localparam int PC_W     = 8;
    localparam int ADDR_W   = PAGE_W + PC_W;
    localparam int IW       = 8;
    localparam int CT_DEPTH = 16;
    localparam int CT_IDX_W = $clog2(CT_DEPTH);
    localparam int STROBE_N = 192;

    localparam logic [IW-1:0] OPC_JMP    = 8'hC0;
    localparam logic [IW-1:0] OPC_JZERO  = 8'hC1;
    localparam logic [IW-1:0] OPC_DECODE = 8'hC2;
    localparam logic [3:0]    GRP_LINK   = 4'hE;
    localparam logic [3:0]    GRP_CORO   = 4'hF;

    typedef enum logic [1:0] {
        ST_BOOT,
        ST_RUN,
        ST_OPND,
        ST_SWAP
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_STROBE,
        OP_JMP,
        OP_JZERO,
        OP_DECODE,
        OP_LINK,
        OP_CORO,
        OP_NOP
    } op_kind_e;

    typedef struct packed {
        op_kind_e              kind;
        logic [CT_IDX_W-1:0]   slot;
        logic [IW-1:0]         code;
    } uop_t;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [PC_W-1:0]   pc;
    } uaddr_t;

    function automatic uop_t classify(input logic [IW-1:0] w);
        uop_t r;
        r.code = w;
        r.slot = w[CT_IDX_W-1:0];
        if (w < IW'(STROBE_N))          r.kind = OP_STROBE;
        else if (w == OPC_JMP)          r.kind = OP_JMP;
        else if (w == OPC_JZERO)        r.kind = OP_JZERO;
        else if (w == OPC_DECODE)       r.kind = OP_DECODE;
        else if (w[7:4] == GRP_LINK)    r.kind = OP_LINK;
        else if (w[7:4] == GRP_CORO)    r.kind = OP_CORO;
        else                            r.kind = OP_NOP;
        return r;
    endfunction

    function automatic uaddr_t step_in_page(input uaddr_t a);
        uaddr_t r;
        r.page = a.page;
        r.pc   = a.pc + 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          en,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (en) rdata <= mem[raddr];
    end
endmodule

// File: rtl/useq_decode.sv
module useq_decode
    import useq_pkg::*;
(
    input  logic [IW-1:0]       ir,
    input  logic                fire,
    output uop_t                op,
    output logic [STROBE_N-1:0] strobe
);
    assign op = classify(ir);

    for (genvar g = 0; g < STROBE_N; g++) begin : g_strobe
        assign strobe[g] = fire && (op.kind == OP_STROBE) && (op.code == IW'(g));
    end
endmodule

// File: rtl/useq_cotable.sv
module useq_cotable #(
    parameter int DEPTH = 16,
    parameter int AW    = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] widx,
    input  logic [AW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] ridx,
    output logic [AW-1:0]            rdata
);
    logic [AW-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (we) begin
            slot_q[widx] <= wdata;
        end
    end

    assign rdata = slot_q[ridx];
endmodule

// File: rtl/microseq.sv
module microseq
    import useq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                hold,
    input  logic [ADDR_W-1:0]   bus_in,
    input  logic                cs_we,
    input  logic [ADDR_W-1:0]   cs_waddr,
    input  logic [IW-1:0]       cs_wdata,
    output logic [ADDR_W-1:0]   uaddr,
    output logic [STROBE_N-1:0] strobe,
    output logic                decode_req
);
    seq_state_e          state_q, state_d;
    uaddr_t              addr_q, addr_d;
    logic [CT_IDX_W-1:0] slot_q, slot_d;
    logic [IW-1:0]       ir_q;
    uop_t                op;
    logic                fire;
    logic                tab_we;
    logic [CT_IDX_W-1:0] tab_widx;
    logic [ADDR_W-1:0]   tab_wdata;
    logic [ADDR_W-1:0]   tab_rdata;
    logic                dispatch;

    assign fire = (state_q == ST_RUN) && !hold;

    useq_store #(.AW(ADDR_W), .DW(IW)) u_store (
        .clk   (clk),
        .en    (!hold),
        .raddr (addr_d),
        .rdata (ir_q),
        .we    (cs_we),
        .waddr (cs_waddr),
        .wdata (cs_wdata)
    );

    useq_decode u_dec (
        .ir     (ir_q),
        .fire   (fire),
        .op     (op),
        .strobe (strobe)
    );

    useq_cotable #(.DEPTH(CT_DEPTH), .AW(ADDR_W)) u_tab (
        .clk   (clk),
        .rst   (rst),
        .we    (tab_we && !hold),
        .widx  (tab_widx),
        .wdata (tab_wdata),
        .ridx  (slot_q),
        .rdata (tab_rdata)
    );

    always_comb begin
        state_d   = state_q;
        addr_d    = addr_q;
        slot_d    = slot_q;
        tab_we    = 1'b0;
        tab_widx  = op.slot;
        tab_wdata = bus_in;
        dispatch  = 1'b0;
        unique case (state_q)
            ST_BOOT: state_d = ST_RUN;
            ST_RUN: begin
                unique case (op.kind)
                    OP_JMP: begin
                        addr_d  = step_in_page(addr_q);
                        state_d = ST_OPND;
                    end
                    OP_JZERO: begin
                        addr_d.page = addr_q.page;
                        addr_d.pc   = '0;
                    end
                    OP_DECODE: begin
                        dispatch = 1'b1;
                        addr_d   = uaddr_t'(bus_in);
                    end
                    OP_LINK: begin
                        tab_we = 1'b1;
                        addr_d = step_in_page(addr_q);
                    end
                    OP_CORO: begin
                        slot_d  = op.slot;
                        addr_d  = step_in_page(addr_q);
                        state_d = ST_SWAP;
                    end
                    default: addr_d = step_in_page(addr_q);
                endcase
            end
            ST_OPND: begin
                addr_d.page = addr_q.page;
                addr_d.pc   = ir_q;
                state_d     = ST_RUN;
            end
            ST_SWAP: begin
                tab_we    = 1'b1;
                tab_widx  = slot_q;
                tab_wdata = addr_q;
                addr_d    = uaddr_t'(tab_rdata);
                state_d   = ST_RUN;
            end
            default: state_d = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BOOT;
            addr_q  <= '0;
            slot_q  <= '0;
        end else if (!hold) begin
            state_q <= state_d;
            addr_q  <= addr_d;
            slot_q  <= slot_d;
        end
    end

    assign uaddr      = addr_q;
    assign decode_req = dispatch && !hold;
endmodule

// File: rtl/microseq_chk.sv
module microseq_chk
    import useq_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                hold,
    input logic [ADDR_W-1:0]   bus_in,
    input logic [ADDR_W-1:0]   uaddr,
    input logic [STROBE_N-1:0] strobe,
    input logic                decode_req,
    input logic [IW-1:0]       ir_q,
    input seq_state_e          state_q
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (uaddr == '0 && strobe == '0 && !decode_req));

    assert_single_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe));

    assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        hold |-> (strobe == '0 && !decode_req));

    assert_hold_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(uaddr));

    assert_dispatch_target_R5: assert property (@(posedge clk) disable iff (rst)
        decode_req |=> (uaddr == $past(bus_in)));

    assert_jump_target_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OPND && !hold) |=>
            (uaddr == {$past(uaddr[ADDR_W-1:PC_W]), $past(ir_q)}));

    assert_zero_jump_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && ir_q == OPC_JZERO && !hold) |=>
            (uaddr[PC_W-1:0] == '0 && uaddr[ADDR_W-1:PC_W] == $past(uaddr[ADDR_W-1:PC_W])));

    assert_swap_second_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && ir_q[7:4] == GRP_CORO && !hold) |=>
            (state_q == ST_SWAP && strobe == '0 && !decode_req));
endmodule

bind microseq microseq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .hold       (hold),
    .bus_in     (bus_in),
    .uaddr      (uaddr),
    .strobe     (strobe),
    .decode_req (decode_req),
    .ir_q       (ir_q),
    .state_q    (state_q)
);

// File: tb/tb_microseq.sv
module tb_microseq;
    import useq_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                hold = 1'b0;
    logic [ADDR_W-1:0]   bus_in = '0;
    logic                cs_we = 1'b0;
    logic [ADDR_W-1:0]   cs_waddr = '0;
    logic [IW-1:0]       cs_wdata = '0;
    logic [ADDR_W-1:0]   uaddr;
    logic [STROBE_N-1:0] strobe;
    logic                decode_req;

    always #2 clk = ~clk;

    microseq dut (
        .clk(clk), .rst(rst), .hold(hold), .bus_in(bus_in),
        .cs_we(cs_we), .cs_waddr(cs_waddr), .cs_wdata(cs_wdata),
        .uaddr(uaddr), .strobe(strobe), .decode_req(decode_req)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    logic [7:0]  img [4096];
    int          m_state;
    logic [11:0] m_addr;
    logic [11:0] m_tab [16];
    logic [3:0]  m_slot;
    string       prev_tag;
    logic [11:0] trace [16];
    logic        trace_dec [16];

    function automatic string tag_now();
        logic [7:0] w = img[m_addr];
        if (hold) return "R8";
        case (m_state)
            0: return "R1";
            2: return "R3";
            3: return "R7";
            default: ;
        endcase
        if (w < 8'hC0) return "R2";
        if (w == 8'hC0) return "R3";
        if (w == 8'hC1) return "R4";
        if (w == 8'hC2) return "R5";
        if (w[7:4] == 4'hE) return "R6";
        if (w[7:4] == 4'hF) return "R7";
        return "R9";
    endfunction

    task automatic check_cycle();
        logic [7:0] w = img[m_addr];
        logic [STROBE_N-1:0] exp_str = '0;
        logic exp_dec = 1'b0;
        string t = tag_now();
        if (!hold && m_state == 1) begin
            if (w < 8'hC0) exp_str[w] = 1'b1;
            else if (w == 8'hC2) exp_dec = 1'b1;
        end
        tests++;
        if (uaddr !== m_addr || strobe !== exp_str || decode_req !== exp_dec) begin
            fails++;
            $display("FAIL %s/%s: uaddr=%h strobe=%h dec=%b expected uaddr=%h strobe=%h dec=%b",
                     prev_tag, t, uaddr, strobe, decode_req, m_addr, exp_str, exp_dec);
        end
        prev_tag = t;
    endtask

    task automatic model_step();
        logic [7:0]  w = img[m_addr];
        logic [11:0] tmp;
        if (hold) return;
        case (m_state)
            0: m_state = 1;
            1: begin
                if (w == 8'hC0) begin
                    m_addr[7:0] = m_addr[7:0] + 8'd1; m_state = 2;
                end else if (w == 8'hC1) begin
                    m_addr[7:0] = 8'd0;
                end else if (w == 8'hC2) begin
                    m_addr = bus_in;
                end else if (w[7:4] == 4'hE) begin
                    m_tab[w[3:0]] = bus_in; m_addr[7:0] = m_addr[7:0] + 8'd1;
                end else if (w[7:4] == 4'hF) begin
                    m_slot = w[3:0]; m_addr[7:0] = m_addr[7:0] + 8'd1; m_state = 3;
                end else begin
                    m_addr[7:0] = m_addr[7:0] + 8'd1;
                end
            end
            2: begin
                m_addr = {m_addr[11:8], w}; m_state = 1;
            end
            default: begin
                tmp = m_tab[m_slot]; m_tab[m_slot] = m_addr; m_addr = tmp; m_state = 1;
            end
        endcase
    endtask

    task automatic load_and_reset();
        rst = 1'b1;
        hold = 1'b0;
        for (int i = 0; i < 4096; i++) begin
            @(negedge clk);
            cs_we = 1'b1; cs_waddr = 12'(i); cs_wdata = img[i];
        end
        @(negedge clk);
        cs_we = 1'b0;
        @(negedge clk);
        m_state = 0; m_addr = '0; m_slot = '0; prev_tag = "R1";
        for (int i = 0; i < 16; i++) m_tab[i] = '0;
        rst = 1'b0;
    endtask

    task automatic run_cycles(input int n, input int hold_pct, input bit directed);
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            if (directed) begin
                hold   = 1'b0;
                bus_in = (m_addr == 12'h001) ? 12'h7A0 : 12'h2FF;
            end else begin
                hold   = (($urandom % 100) < hold_pct);
                bus_in = 12'($urandom);
            end
            #1;
            check_cycle();
            if (directed && i < 16) begin
                trace[i] = uaddr;
                trace_dec[i] = decode_req;
            end
            model_step();
        end
    endtask

    task automatic expect_addr(input int k, input logic [11:0] e, input string req);
        tests++;
        if (trace[k] !== e) begin
            fails++;
            $display("FAIL %s: step %0d uaddr=%h expected %h", req, k, trace[k], e);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));

        // Directed program: R11 image loaded through the write port.
        for (int i = 0; i < 4096; i++) img[i] = 8'h00;
        img[12'h000] = 8'h05;
        img[12'h001] = 8'hE3;
        img[12'h002] = 8'hC0;
        img[12'h003] = 8'h40;
        img[12'h040] = 8'hF3;
        img[12'h041] = 8'hC2;
        img[12'h7A0] = 8'h11;
        img[12'h7A1] = 8'hC1;
        img[12'h700] = 8'hF3;
        img[12'h2FF] = 8'h22;
        img[12'h200] = 8'hC1;
        load_and_reset();
        run_cycles(16, 0, 1'b1);

        expect_addr(0,  12'h000, "R1");
        expect_addr(1,  12'h000, "R11");
        expect_addr(2,  12'h001, "R2");
        expect_addr(4,  12'h003, "R3");
        expect_addr(5,  12'h040, "R3");
        expect_addr(7,  12'h7A0, "R6");
        expect_addr(9,  12'h700, "R4");
        expect_addr(11, 12'h041, "R7");
        expect_addr(12, 12'h2FF, "R5");
        expect_addr(13, 12'h200, "R2");
        expect_addr(14, 12'h200, "R4");
        tests++;
        if (trace_dec[11] !== 1'b1) begin
            fails++;
            $display("FAIL R5: decode_req=%b expected 1", trace_dec[11]);
        end

        // R8: frozen for several cycles, then released.
        @(negedge clk);
        run_cycles(8, 100, 1'b0);
        @(negedge clk);
        run_cycles(8, 0, 1'b0);

        // Random program with random hold (R2..R10).
        for (int i = 0; i < 4096; i++) begin
            int r = int'($urandom % 100);
            if (r < 55)      img[i] = 8'($urandom % 192);
            else if (r < 62) img[i] = 8'hC0;
            else if (r < 67) img[i] = 8'hC1;
            else if (r < 72) img[i] = 8'hC2;
            else if (r < 79) img[i] = {4'hE, 4'($urandom)};
            else if (r < 89) img[i] = {4'hF, 4'($urandom)};
            else             img[i] = 8'(8'hC3 + ($urandom % 29));
        end
        load_and_reset();
        run_cycles(6000, 20, 1'b0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule